// File: doc/BRIEF.md
# System-Management Context Save/Restore Sequencer

This block moves a simple 32-bit CPU into and out of a system-management mode. A management request makes it copy the CPU register set into a fixed dump region at the top of a dedicated memory window. It writes one 32-bit word per accepted beat, working from the highest slot toward lower addresses. After the registers it stores the two 16-bit restart slots and a revision identifier. An active-low in-mode indicator drops as the save begins and stays low for the whole time the mode lasts.

A resume command is legal only while the mode is active. It reads the stored words back in the reverse of the save order and loads them onto a flat register output bus. After the last word is loaded the indicator goes high again and a done pulse is raised. A resume outside the mode is dropped and raises an illegal-operation pulse instead. The block also tells the CPU side when an access to the management window is blocked because the mode is not active.

The sequencer has four states. ST_IDLE is outside the mode. ST_SAVE writes the dump. ST_INMODE waits for the handler to finish. ST_RESTORE reads the dump back. Its transitions are:

- IDLE→SAVE, on a request or a pending request.
- SAVE→INMODE, on the accepted revision write.
- INMODE→RESTORE, on a resume.
- RESTORE→IDLE, on the accepted final read.

Top module: `mgmt_ctx_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the outputs are at rest: `in_mode_n` is 1, and `mem_valid`, `restore_done` and `resume_illegal` are 0.
- R2: The save writes the 22 registers of `ctx_in` (slot k is bits 32k+31..32k) to word addresses 3FFFCh − 4k. The slots run CR0, CR3, EFLAGS, EIP, EDI, ESI, EBP, ESP, EBX, EDX (3FFD8h), ECX, EAX, DR6, DR7, TR, LDTR, GS, FS, DS, SS, CS, ES, and the last one is at 3FFA8h. All these beats have `mem_we` = 1.
- R3: After the registers, the save writes {`halt_slot_in`, `io_slot_in`} to 3FF00h, which puts the halt slot at byte 3FF02h and the I/O slot at 3FF00h. It then writes 00010000h to 3FEFCh. That makes 24 beats in total, after which `mem_valid` is 0.
- R4: `in_mode_n` goes low in the cycle after a request is accepted in ST_IDLE. It stays low through the save, the in-mode wait and the restore. No memory access happens while `in_mode_n` is high.
- R5: At most one word moves per clock, and only on a cycle with `mem_valid` and `mem_ready` both high. While `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and the write data hold still.
- R6: A resume while in the mode makes 23 reads (`mem_we` = 0). They go to 3FF00h first and then to 3FFA8h up through 3FFFCh in steps of 4. Each read word is loaded into its slot of `ctx_out`, and the word from 3FF00h is split onto `halt_slot_out` (upper half) and `io_slot_out` (lower half). The revision word is not read.
- R7: In the cycle after the final read is accepted, `in_mode_n` is 1 and `restore_done` is 1 for exactly that one cycle.
- R8: A resume while out of the mode causes no memory access and leaves `in_mode_n` at 1. `resume_illegal` is 1 for exactly the following cycle.
- R9: A request that arrives during ST_SAVE or ST_RESTORE is held pending. It starts a new save right after the restore completes, so `in_mode_n` is high for one cycle only. A request in ST_INMODE is dropped and causes no memory access.
- R10: `cpu_blocked` is combinationally 1 exactly when `cpu_req` is 1, `cpu_addr` lies in 38000h..3FFFFh, and `in_mode_n` is 1.
- R11: Every memory access is word aligned and lies within 3FE00h..3FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_req | input | 1 | Management-mode entry request |
| resume_req | input | 1 | Resume command |
| ctx_in | input | 704 | Flat CPU register set, 22 slots of 32 bits |
| halt_slot_in | input | 16 | Halt-restart slot value to save |
| io_slot_in | input | 16 | I/O-trap-restart slot value to save |
| mem_valid | output | 1 | Memory beat offered |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |
| ctx_out | output | 704 | Restored register set |
| halt_slot_out | output | 16 | Restored halt-restart slot |
| io_slot_out | output | 16 | Restored I/O-trap-restart slot |
| in_mode_n | output | 1 | Low while the mode is active |
| restore_done | output | 1 | One-cycle pulse when the restore finishes |
| resume_illegal | output | 1 | One-cycle pulse on a resume outside the mode |
| cpu_req | input | 1 | CPU memory access strobe |
| cpu_addr | input | 20 | CPU access byte address |
| cpu_blocked | output | 1 | Access to the window is refused |

## Verification
`cpu_blocked` is combinational, so its table is checked 1 ns after the inputs change, with no clock edge in between. `in_mode_n` and `resume_illegal` come from a single register stage, so they are sampled at the falling edge after the edge that saw the request or the resume. Beats are logged at the edge that accepts them. Each save or restore result is therefore checked at the first falling edge after the log reaches the expected beat count, which is the cycle where `restore_done` and the rising `in_mode_n` are due. Because of this, a randomly stalling `mem_ready` changes none of the expected values.

// File: rtl/mgmt_ctx_pkg.sv
package mgmt_ctx_pkg;
    localparam int ADDR_W   = 20;
    localparam int WORD_W   = 32;
    localparam int SLOT_W   = 16;
    localparam int NUM_REGS = 22;
    localparam int NUM_SAVE = NUM_REGS + 2;
    localparam int IDX_W    = $clog2(NUM_SAVE + 1);

    localparam logic [ADDR_W-1:0] WIN_LO        = 20'h38000;
    localparam logic [ADDR_W-1:0] WIN_HI        = 20'h3FFFF;
    localparam logic [ADDR_W-1:0] DUMP_LO       = 20'h3FE00;
    localparam logic [ADDR_W-1:0] DUMP_TOP_WORD = 20'h3FFFC;
    localparam logic [ADDR_W-1:0] RESTART_WORD  = 20'h3FF00;
    localparam logic [ADDR_W-1:0] REV_WORD      = 20'h3FEFC;
    localparam logic [WORD_W-1:0] REV_ID        = 32'h0001_0000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAVE,
        ST_INMODE,
        ST_RESTORE
    } seq_state_e;
endpackage

// File: rtl/mgmt_ctx_fsm.sv
module mgmt_ctx_fsm
    import mgmt_ctx_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int IW   = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mgmt_req,
    input  logic          resume_req,
    input  logic          beat,
    output logic [IW-1:0] idx,
    output logic          mem_valid,
    output logic          mem_we,
    output logic          in_mode_n,
    output logic          load_en,
    output logic          restore_done,
    output logic          resume_illegal
);
    localparam logic [IW-1:0] SAVE_LAST     = IW'(NREG + 1);
    localparam logic [IW-1:0] RESTORE_FIRST = IW'(NREG);

    seq_state_e    state_q;
    logic [IW-1:0] idx_q;
    logic          pend_q;
    logic          done_q;
    logic          illegal_q;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            pend_q    <= 1'b0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            illegal_q <= resume_req && (state_q == ST_IDLE);
            unique case (state_q)
                ST_IDLE: begin
                    if (mgmt_req || pend_q) begin
                        state_q <= ST_SAVE;
                        idx_q   <= '0;
                        pend_q  <= 1'b0;
                    end
                end
                ST_SAVE: begin
                    if (mgmt_req) pend_q <= 1'b1;
                    if (beat) begin
                        if (idx_q == SAVE_LAST) state_q <= ST_INMODE;
                        else                    idx_q   <= idx_q + 1'b1;
                    end
                end
                ST_INMODE: begin
                    if (resume_req) begin
                        state_q <= ST_RESTORE;
                        idx_q   <= RESTORE_FIRST;
                    end
                end
                ST_RESTORE: begin
                    if (mgmt_req) pend_q <= 1'b1;
                    if (beat) begin
                        if (idx_q == '0) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q - 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        mem_valid      = (state_q == ST_SAVE) || (state_q == ST_RESTORE);
        mem_we         = (state_q == ST_SAVE);
        in_mode_n      = (state_q == ST_IDLE);
        load_en        = (state_q == ST_RESTORE) && beat;
        idx            = idx_q;
        restore_done   = done_q;
        resume_illegal = illegal_q;
    end
endmodule

// File: rtl/mgmt_ctx_slotmap.sv
module mgmt_ctx_slotmap
    import mgmt_ctx_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int IW   = IDX_W
) (
    input  logic [IW-1:0]          idx,
    input  logic [NREG*WORD_W-1:0] ctx_in,
    input  logic [SLOT_W-1:0]      halt_in,
    input  logic [SLOT_W-1:0]      io_in,
    output logic [ADDR_W-1:0]      addr,
    output logic [WORD_W-1:0]      wdata
);
    localparam int PAD_W = ADDR_W - IW - 2;

    logic [WORD_W-1:0] reg_word;

    always_comb begin
        reg_word = '0;
        for (int k = 0; k < NREG; k++) begin
            if (idx == IW'(k)) reg_word = ctx_in[k*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        if (idx < IW'(NREG)) begin
            addr  = DUMP_TOP_WORD - {{PAD_W{1'b0}}, idx, 2'b00};
            wdata = reg_word;
        end else if (idx == IW'(NREG)) begin
            addr  = RESTART_WORD;
            wdata = {halt_in, io_in};
        end else begin
            addr  = REV_WORD;
            wdata = REV_ID;
        end
    end
endmodule

// File: rtl/mgmt_ctx_restore_bank.sv
module mgmt_ctx_restore_bank
    import mgmt_ctx_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int IW   = IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [IW-1:0]          idx,
    input  logic [WORD_W-1:0]      rdata,
    output logic [NREG*WORD_W-1:0] ctx_out,
    output logic [SLOT_W-1:0]      halt_out,
    output logic [SLOT_W-1:0]      io_out
);
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               word_q <= '0;
            else if (load_en && (idx == IW'(g)))      word_q <= rdata;
        end
        assign ctx_out[g*WORD_W +: WORD_W] = word_q;
    end

    logic [WORD_W-1:0] restart_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   restart_q <= '0;
        else if (load_en && (idx == IW'(NREG)))       restart_q <= rdata;
    end
    assign halt_out = restart_q[WORD_W-1 -: SLOT_W];
    assign io_out   = restart_q[SLOT_W-1:0];
endmodule

// File: rtl/mgmt_ctx_window_gate.sv
module mgmt_ctx_window_gate
    import mgmt_ctx_pkg::*;
#(
    parameter int                AW = ADDR_W,
    parameter logic [AW-1:0]     LO = WIN_LO,
    parameter logic [AW-1:0]     HI = WIN_HI
) (
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic          in_mode_n,
    output logic          cpu_blocked
);
    always_comb begin
        cpu_blocked = cpu_req && in_mode_n && (cpu_addr >= LO) && (cpu_addr <= HI);
    end
endmodule

// File: rtl/mgmt_ctx_seq.sv
module mgmt_ctx_seq
    import mgmt_ctx_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int IW   = IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mgmt_req,
    input  logic                   resume_req,
    input  logic [NREG*WORD_W-1:0] ctx_in,
    input  logic [SLOT_W-1:0]      halt_slot_in,
    input  logic [SLOT_W-1:0]      io_slot_in,
    output logic                   mem_valid,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [WORD_W-1:0]      mem_wdata,
    input  logic                   mem_ready,
    input  logic [WORD_W-1:0]      mem_rdata,
    output logic [NREG*WORD_W-1:0] ctx_out,
    output logic [SLOT_W-1:0]      halt_slot_out,
    output logic [SLOT_W-1:0]      io_slot_out,
    output logic                   in_mode_n,
    output logic                   restore_done,
    output logic                   resume_illegal,
    input  logic                   cpu_req,
    input  logic [ADDR_W-1:0]      cpu_addr,
    output logic                   cpu_blocked
);
    logic [IW-1:0] idx;
    logic          load_en;
    logic          beat;

    assign beat = mem_valid && mem_ready;

    mgmt_ctx_fsm #(.NREG(NREG), .IW(IW)) fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .mgmt_req       (mgmt_req),
        .resume_req     (resume_req),
        .beat           (beat),
        .idx            (idx),
        .mem_valid      (mem_valid),
        .mem_we         (mem_we),
        .in_mode_n      (in_mode_n),
        .load_en        (load_en),
        .restore_done   (restore_done),
        .resume_illegal (resume_illegal)
    );

    mgmt_ctx_slotmap #(.NREG(NREG), .IW(IW)) map_i (
        .idx     (idx),
        .ctx_in  (ctx_in),
        .halt_in (halt_slot_in),
        .io_in   (io_slot_in),
        .addr    (mem_addr),
        .wdata   (mem_wdata)
    );

    mgmt_ctx_restore_bank #(.NREG(NREG), .IW(IW)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .idx      (idx),
        .rdata    (mem_rdata),
        .ctx_out  (ctx_out),
        .halt_out (halt_slot_out),
        .io_out   (io_slot_out)
    );

    mgmt_ctx_window_gate gate_i (
        .cpu_req     (cpu_req),
        .cpu_addr    (cpu_addr),
        .in_mode_n   (in_mode_n),
        .cpu_blocked (cpu_blocked)
    );
endmodule

// File: rtl/mgmt_ctx_seq_chk.sv
module mgmt_ctx_seq_chk
    import mgmt_ctx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              in_mode_n,
    input logic              restore_done,
    input logic              resume_illegal,
    input logic              resume_req,
    input logic              cpu_blocked
);
    a_r5_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    a_r5_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we && !mem_ready) |=> $stable(mem_wdata));

    a_r4_access_only_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !in_mode_n);

    a_r7_done_with_exit: assert property (@(posedge clk) disable iff (!rst_n)
        restore_done |-> (in_mode_n && $past(!in_mode_n)));

    a_r8_illegal_outside: assert property (@(posedge clk) disable iff (!rst_n)
        resume_illegal |-> ($past(resume_req) && $past(in_mode_n) && !mem_valid));

    a_r11_addr_in_dump: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((mem_addr >= DUMP_LO) && (mem_addr <= WIN_HI) && (mem_addr[1:0] == 2'b00)));

    a_r10_block_only_outside: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_blocked |-> in_mode_n);
endmodule

bind mgmt_ctx_seq mgmt_ctx_seq_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .mem_valid      (mem_valid),
    .mem_ready      (mem_ready),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .in_mode_n      (in_mode_n),
    .restore_done   (restore_done),
    .resume_illegal (resume_illegal),
    .resume_req     (resume_req),
    .cpu_blocked    (cpu_blocked)
);

// File: tb/mgmt_ctx_seq_tb_top.sv
module mgmt_ctx_seq_tb_top;
    import mgmt_ctx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NR         = NUM_REGS;
    localparam int WAIT_LIM   = 2000;
    // {address, expected block while out of the mode}  (R10)
    localparam logic [20:0] WIN_VEC [10] = '{
        {20'h37FFF, 1'b0}, {20'h38000, 1'b1}, {20'h38004, 1'b1}, {20'h3C000, 1'b1},
        {20'h3FE00, 1'b1}, {20'h3FFFF, 1'b1}, {20'h40000, 1'b0}, {20'h00000, 1'b0},
        {20'hFFFFF, 1'b0}, {20'h1FFFF, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic                mgmt_req = 1'b0, resume_req = 1'b0;
    logic [NR*32-1:0]    ctx_in = '0;
    logic [15:0]         halt_slot_in = '0, io_slot_in = '0;
    logic                mem_valid, mem_we, mem_ready;
    logic [19:0]         mem_addr;
    logic [31:0]         mem_wdata, mem_rdata;
    logic [NR*32-1:0]    ctx_out;
    logic [15:0]         halt_slot_out, io_slot_out;
    logic                in_mode_n, restore_done, resume_illegal;
    logic                cpu_req = 1'b0;
    logic [19:0]         cpu_addr = '0;
    logic                cpu_blocked;

    mgmt_ctx_seq dut_i (
        .clk(clk), .rst_n(rst_n), .mgmt_req(mgmt_req), .resume_req(resume_req),
        .ctx_in(ctx_in), .halt_slot_in(halt_slot_in), .io_slot_in(io_slot_in),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .ctx_out(ctx_out),
        .halt_slot_out(halt_slot_out), .io_slot_out(io_slot_out), .in_mode_n(in_mode_n),
        .restore_done(restore_done), .resume_illegal(resume_illegal),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_blocked(cpu_blocked)
    );

    // memory model over the dump region, with beat log
    logic [31:0] model [0:127] = '{default: 32'h0};
    logic [19:0] log_addr [0:255];
    logic        log_we   [0:255];
    logic [31:0] log_data [0:255];
    int          nbeat = 0;
    logic        poke_en = 1'b0;
    logic [6:0]  poke_idx = '0;
    logic [31:0] poke_val = '0;

    always @(posedge clk) begin
        if (poke_en) model[poke_idx] <= poke_val;
        if (mem_valid && mem_ready) begin
            if (nbeat < 256) begin
                log_addr[nbeat] <= mem_addr;
                log_we[nbeat]   <= mem_we;
                log_data[nbeat] <= mem_we ? mem_wdata : mem_rdata;
            end
            if (mem_we) model[mem_addr[8:2]] <= mem_wdata;
            nbeat <= nbeat + 1;
        end
    end
    assign mem_rdata = model[mem_addr[8:2]];

    logic       stall_mode = 1'b0;
    logic [7:0] lfsr = 8'hA7;
    logic       ready_q = 1'b1;
    always @(negedge clk) begin
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ready_q <= stall_mode ? lfsr[0] : 1'b1;
    end
    assign mem_ready = ready_q;

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] pat(input logic [7:0] seed, input int i);
        return {seed, 8'(i), 16'hC0DE ^ 16'(i * 37)};
    endfunction

    function automatic logic [NR*32-1:0] make_ctx(input logic [7:0] seed);
        logic [NR*32-1:0] v;
        for (int i = 0; i < NR; i++) v[i*32 +: 32] = pat(seed, i);
        return v;
    endfunction

    function automatic logic [19:0] exp_addr(input int k);
        if (k < NR)       return 20'h3FFFC - 20'(4 * k);
        else if (k == NR) return 20'h3FF00;
        else              return 20'h3FEFC;
    endfunction

    task automatic wait_beats(input int target, input string req);
        int n = 0;
        while (nbeat < target && n < WAIT_LIM) begin
            @(negedge clk);
            n++;
        end
        chk(req, "beat count reached", 32'(nbeat), 32'(target));
    endtask

    task automatic pulse_mgmt();
        @(negedge clk); mgmt_req = 1'b1;
        @(negedge clk); mgmt_req = 1'b0;
    endtask

    task automatic pulse_resume();
        @(negedge clk); resume_req = 1'b1;
        @(negedge clk); resume_req = 1'b0;
    endtask

    task automatic check_save_log(input int base, input logic [7:0] seed, input logic [15:0] h, input logic [15:0] io);
        for (int k = 0; k < NR + 2; k++) begin
            logic [31:0] ed;
            string r;
            r  = (k < NR) ? "R2" : "R3";
            ed = (k < NR) ? pat(seed, k) : (k == NR) ? {h, io} : 32'h0001_0000;
            chk(r, $sformatf("save beat %0d addr", k), 32'(log_addr[base+k]), 32'(exp_addr(k)));
            chk(r, $sformatf("save beat %0d we", k), 32'(log_we[base+k]), 32'd1);
            chk(r, $sformatf("save beat %0d data", k), log_data[base+k], ed);
        end
    endtask

    task automatic check_restore_log(input int base);
        for (int j = 0; j <= NR; j++) begin
            chk("R6", $sformatf("restore beat %0d addr", j), 32'(log_addr[base+j]), 32'(exp_addr(NR - j)));
            chk("R6", $sformatf("restore beat %0d we", j), 32'(log_we[base+j]), 32'd0);
        end
    endtask

    task automatic check_window(input logic exp_outside, input string tag);
        for (int v = 0; v < 10; v++) begin
            cpu_req  = 1'b1;
            cpu_addr = WIN_VEC[v][20:1];
            #1;
            chk("R10", $sformatf("%s addr %h", tag, cpu_addr), 32'(cpu_blocked),
                32'(WIN_VEC[v][0] & exp_outside));
        end
        cpu_req  = 1'b0;
        cpu_addr = 20'h38000;
        #1;
        chk("R10", {tag, " no strobe"}, 32'(cpu_blocked), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        logic saw_high;
        logic [31:0] exp_w;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "in_mode_n in reset", 32'(in_mode_n), 32'd1);
        chk("R1", "mem_valid in reset", 32'(mem_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "in_mode_n after reset", 32'(in_mode_n), 32'd1);
        chk("R1", "mem_valid after reset", 32'(mem_valid), 32'd0);
        chk("R1", "done after reset", 32'(restore_done), 32'd0);
        chk("R1", "illegal after reset", 32'(resume_illegal), 32'd0);

        // R10 window gating outside the mode
        check_window(1'b1, "outside");

        // R8 resume outside the mode
        base = nbeat;
        resume_req = 1'b1;
        @(negedge clk); resume_req = 1'b0;
        chk("R8", "illegal pulse", 32'(resume_illegal), 32'd1);
        chk("R8", "in_mode_n unchanged", 32'(in_mode_n), 32'd1);
        chk("R8", "no access", 32'(mem_valid), 32'd0);
        @(negedge clk);
        chk("R8", "illegal one cycle", 32'(resume_illegal), 32'd0);
        repeat (3) @(negedge clk);
        chk("R8", "no beats", 32'(nbeat), 32'(base));

        // save 1, ready always high
        ctx_in = make_ctx(8'h11); halt_slot_in = 16'h0001; io_slot_in = 16'h00A5;
        base = nbeat;
        pulse_mgmt();
        chk("R4", "indicator low after request", 32'(in_mode_n), 32'd0);
        chk("R2", "first addr", 32'(mem_addr), 32'h3FFFC);
        saw_high = 1'b0;
        while (nbeat < base + NR + 2) begin
            @(negedge clk);
            if (in_mode_n) saw_high = 1'b1;
        end
        chk("R4", "indicator held during save", 32'(saw_high), 32'd0);
        chk("R3", "valid drops after 24 beats", 32'(mem_valid), 32'd0);
        @(negedge clk);
        chk("R3", "still 24 beats", 32'(nbeat - base), 32'd24);
        check_save_log(base, 8'h11, 16'h0001, 16'h00A5);

        // R10 inside the mode
        check_window(1'b0, "inside");

        // R9 request in the mode is dropped
        base = nbeat;
        pulse_mgmt();
        repeat (4) @(negedge clk);
        chk("R9", "no beats on in-mode request", 32'(nbeat), 32'(base));
        chk("R4", "indicator low in mode", 32'(in_mode_n), 32'd0);

        // alter the stored EIP word so the restore must come from memory
        @(negedge clk); poke_en = 1'b1; poke_idx = exp_addr(3) >> 2; poke_val = 32'hDEAD_BEEF;
        @(negedge clk); poke_en = 1'b0;

        // restore 1
        base = nbeat;
        pulse_resume();
        chk("R6", "first read addr", 32'(mem_addr), 32'h3FF00);
        chk("R6", "first read is read", 32'(mem_we), 32'd0);
        wait_beats(base + NR + 1, "R6");
        chk("R7", "indicator high after last read", 32'(in_mode_n), 32'd1);
        chk("R7", "done pulse", 32'(restore_done), 32'd1);
        @(negedge clk);
        chk("R7", "done one cycle", 32'(restore_done), 32'd0);
        chk("R7", "stays out of mode", 32'(in_mode_n), 32'd1);
        check_restore_log(base);
        for (int i = 0; i < NR; i++) begin
            exp_w = (i == 3) ? 32'hDEAD_BEEF : pat(8'h11, i);
            chk("R6", $sformatf("ctx_out slot %0d", i), ctx_out[i*32 +: 32], exp_w);
        end
        chk("R6", "halt slot out", 32'(halt_slot_out), 32'h0001);
        chk("R6", "io slot out", 32'(io_slot_out), 32'h00A5);

        // save 2 with stalls and a pending request
        stall_mode = 1'b1;
        ctx_in = make_ctx(8'h22); halt_slot_in = 16'hBEEF; io_slot_in = 16'h1234;
        base = nbeat;
        pulse_mgmt();
        wait_beats(base + 10, "R5");
        pulse_mgmt();
        wait_beats(base + NR + 2, "R5");
        check_save_log(base, 8'h22, 16'hBEEF, 16'h1234);
        repeat (4) @(negedge clk);
        chk("R9", "pending waits while in mode", 32'(nbeat - base), 32'd24);

        base = nbeat;
        pulse_resume();
        wait_beats(base + NR + 1, "R6");
        chk("R7", "done under stalls", 32'(restore_done), 32'd1);
        chk("R9", "single idle cycle", 32'(in_mode_n), 32'd1);
        check_restore_log(base);
        for (int i = 0; i < NR; i++)
            chk("R6", $sformatf("stalled ctx_out slot %0d", i), ctx_out[i*32 +: 32], pat(8'h22, i));
        chk("R6", "halt slot out 2", 32'(halt_slot_out), 32'hBEEF);
        chk("R6", "io slot out 2", 32'(io_slot_out), 32'h1234);
        @(negedge clk);
        chk("R9", "pending save started", 32'(in_mode_n), 32'd0);
        chk("R9", "pending save writing", 32'(mem_valid & mem_we), 32'd1);

        // save 3 (from pending), restore 3, then nothing more
        base = nbeat;
        wait_beats(base + NR + 2, "R9");
        check_save_log(base, 8'h22, 16'hBEEF, 16'h1234);
        base = nbeat;
        pulse_resume();
        wait_beats(base + NR + 1, "R7");
        chk("R7", "final done", 32'(restore_done), 32'd1);
        base = nbeat;
        repeat (5) @(negedge clk);
        chk("R9", "pending cleared", 32'(nbeat), 32'(base));
        chk("R9", "stays out of mode", 32'(in_mode_n), 32'd1);

        finish_run();
    end
endmodule